// File: doc/BRIEF.md
# Hybrid-Index Gshare Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps a table of 2-bit saturating counters. A lookup presents a fetch PC. The block forms a table index from that PC and a global branch history register, and returns the predicted direction. It also returns the index it used and the history value it saw. The front end stores that pair with the branch.

When the branch resolves, the stored index, the stored history, the prediction and the real outcome come back on the update port. The update trains the counter at that index. It also raises a mispredict flag for the cycle, so that the pipeline can start its drain of roughly eight cycles. On a misprediction the history register is rebuilt from the stored snapshot followed by the real outcome.

The index is a hybrid. Its lowest `LOW_W` bits (three by default) come from the PC alone. Only the bits above them are the PC XORed with the history. The history width therefore equals the index width minus `LOW_W`. The full-size setting is `IDX_W = 14`, which gives 16K counters and an 11-bit history. The default is smaller so that elaboration stays light.

Top module: `gsp_hybrid_predictor`

## Requirements
- R1: After reset every counter holds 01 (weakly not-taken), so every lookup predicts not-taken, and the history register reads zero.
- R2: Index bits [LOW_W-1:0] equal PC bits [ALIGN+LOW_W-1:ALIGN], whatever the history holds.
- R3: Index bits [IDX_W-1:LOW_W] equal PC bits [ALIGN+IDX_W-1:ALIGN+LOW_W] XOR the current history, with history bit 0 aligned to index bit LOW_W.
- R4: The predicted direction is bit 1 (the MSB) of the indexed counter: 1 means taken.
- R5: A counter at 3 stays at 3 when trained taken, and a counter at 0 stays at 0 when trained not-taken.
- R6: An update adds one to the counter at the update index when the outcome is taken and subtracts one when it is not-taken, within the limits of R5.
- R7: A lookup with no mispredicting update in the same cycle shifts the predicted direction into history bit 0; the older bits move up by one and the top bit is dropped.
- R8: A mispredicting update sets the history to {stored snapshot shifted up by one, actual outcome}. If a lookup happens in the same cycle, it then shifts its own prediction in on top of that value.
- R9: A cycle with no lookup and no mispredicting update leaves the history unchanged, and this includes a correctly predicted update.
- R10: The mispredict output is 1 exactly when an update is valid and the supplied prediction differs from the actual outcome; the flag is combinational.
- R11: When a lookup and an update address the same entry in the same cycle, the lookup returns the counter value from before the update.
- R12: The lookup returns the history value that it used to form its index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| lk_valid | input | 1 | Lookup request this cycle |
| lk_pc | input | PC_W | Fetch PC of the branch |
| lk_taken | output | 1 | Predicted direction |
| lk_idx | output | IDX_W | Table index used by the lookup |
| lk_hist | output | IDX_W-LOW_W | History snapshot used by the lookup |
| up_valid | input | 1 | Resolved branch update |
| up_idx | input | IDX_W | Index returned by that branch's lookup |
| up_hist | input | IDX_W-LOW_W | History snapshot returned by that lookup |
| up_pred | input | 1 | Direction that was predicted |
| up_taken | input | 1 | Actual direction |
| up_mispredict | output | 1 | Update was mispredicted |

## Verification
The bound checker checks the history rules on every cycle: the shift on a lookup, the restore on a misprediction, and the hold when neither happens. It also checks the PC-only low index bits, the conditions under which the mispredict flag stays low, and the zero history after reset. Counter contents are not visible at the ports, so saturation, the training steps and the read-before-write collision can only be shown by the bench. Its scenarios drive a counter past both limits, sweep every PC slot under every history value, and compare each prediction against a bench model of the table.

// File: rtl/gsp_pkg.sv
package gsp_pkg;

    typedef logic [1:0] ctr_t;

    localparam ctr_t CTR_INIT = 2'b01;

    function automatic ctr_t ctr_train(input ctr_t c, input logic taken);
        ctr_t r;
        r = c;
        if (taken && c != 2'b11) begin
            r = c + 2'd1;
        end else if (!taken && c != 2'b00) begin
            r = c - 2'd1;
        end
        return r;
    endfunction

endpackage

// File: rtl/gsp_index_hash.sv
module gsp_index_hash #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 10,
    parameter int LOW_W = 3,
    parameter int ALIGN = 2,
    localparam int HIST_W = IDX_W - LOW_W
) (
    input  logic [PC_W-1:0]   pc,
    input  logic [HIST_W-1:0] hist,
    output logic [IDX_W-1:0]  idx
);
    generate
        if (LOW_W == 0) begin : g_plain
            assign idx = pc[ALIGN+IDX_W-1:ALIGN] ^ hist;
        end else begin : g_hybrid
            assign idx[LOW_W-1:0]     = pc[ALIGN+LOW_W-1:ALIGN];
            assign idx[IDX_W-1:LOW_W] = pc[ALIGN+IDX_W-1:ALIGN+LOW_W] ^ hist;
        end
    endgenerate
endmodule

// File: rtl/gsp_ghr.sv
module gsp_ghr #(
    parameter int HIST_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_en,
    input  logic              shift_bit,
    input  logic              fix_en,
    input  logic [HIST_W-1:0] fix_hist,
    input  logic              fix_bit,
    output logic [HIST_W-1:0] hist
);
    typedef struct packed {
        logic [HIST_W-1:0] hist;
    } ghr_state_t;

    ghr_state_t state_d, state_q;
    logic [HIST_W-1:0] base;

    always_comb begin
        state_d = state_q;
        base    = state_q.hist;
        if (fix_en) begin
            base = {fix_hist[HIST_W-2:0], fix_bit};
        end
        if (shift_en) begin
            state_d.hist = {base[HIST_W-2:0], shift_bit};
        end else begin
            state_d.hist = base;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign hist = state_q.hist;
endmodule

// File: rtl/gsp_ctr_table.sv
module gsp_ctr_table
    import gsp_pkg::*;
#(
    parameter int IDX_W = 10,
    localparam int DEPTH = 1 << IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] rd_idx,
    output ctr_t             rd_ctr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);
    ctr_t tbl_d [DEPTH];
    ctr_t tbl_q [DEPTH];

    always_comb begin
        tbl_d = tbl_q;
        if (wr_en) begin
            tbl_d[wr_idx] = ctr_train(tbl_q[wr_idx], wr_taken);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                tbl_q[i] <= CTR_INIT;
            end
        end else begin
            tbl_q <= tbl_d;
        end
    end

    assign rd_ctr = tbl_q[rd_idx];
endmodule

// File: rtl/gsp_hybrid_predictor.sv
module gsp_hybrid_predictor
    import gsp_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int IDX_W = 10,
    parameter int LOW_W = 3,
    parameter int ALIGN = 2,
    localparam int HIST_W = IDX_W - LOW_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              lk_valid,
    input  logic [PC_W-1:0]   lk_pc,
    output logic              lk_taken,
    output logic [IDX_W-1:0]  lk_idx,
    output logic [HIST_W-1:0] lk_hist,
    input  logic              up_valid,
    input  logic [IDX_W-1:0]  up_idx,
    input  logic [HIST_W-1:0] up_hist,
    input  logic              up_pred,
    input  logic              up_taken,
    output logic              up_mispredict
);
    logic [HIST_W-1:0] hist;
    ctr_t              rd_ctr;

    gsp_index_hash #(
        .PC_W (PC_W),
        .IDX_W(IDX_W),
        .LOW_W(LOW_W),
        .ALIGN(ALIGN)
    ) u_hash (
        .pc  (lk_pc),
        .hist(hist),
        .idx (lk_idx)
    );

    gsp_ctr_table #(
        .IDX_W(IDX_W)
    ) u_table (
        .clk     (clk),
        .rst     (rst),
        .rd_idx  (lk_idx),
        .rd_ctr  (rd_ctr),
        .wr_en   (up_valid),
        .wr_idx  (up_idx),
        .wr_taken(up_taken)
    );

    assign lk_taken      = rd_ctr[1];
    assign up_mispredict = up_valid && (up_pred != up_taken);

    gsp_ghr #(
        .HIST_W(HIST_W)
    ) u_ghr (
        .clk      (clk),
        .rst      (rst),
        .shift_en (lk_valid),
        .shift_bit(lk_taken),
        .fix_en   (up_mispredict),
        .fix_hist (up_hist),
        .fix_bit  (up_taken),
        .hist     (hist)
    );

    assign lk_hist = hist;
endmodule

// File: rtl/gsp_checker.sv
module gsp_checker #(
    parameter int PC_W  = 32,
    parameter int IDX_W = 10,
    parameter int LOW_W = 3,
    parameter int ALIGN = 2,
    localparam int HIST_W = IDX_W - LOW_W
) (
    input logic              clk,
    input logic              rst,
    input logic              lk_valid,
    input logic [PC_W-1:0]   lk_pc,
    input logic              lk_taken,
    input logic [IDX_W-1:0]  lk_idx,
    input logic [HIST_W-1:0] lk_hist,
    input logic              up_valid,
    input logic [HIST_W-1:0] up_hist,
    input logic              up_pred,
    input logic              up_taken,
    input logic              up_mispredict
);
    // R1
    hist_clear_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> lk_hist == '0);

    // R2
    low_index_pc_only_chk: assert property (@(posedge clk) disable iff (rst)
        lk_valid |-> lk_idx[LOW_W-1:0] == lk_pc[ALIGN+LOW_W-1:ALIGN]);

    // R7
    lookup_shift_chk: assert property (@(posedge clk) disable iff (rst)
        (lk_valid && !up_mispredict) |=>
            lk_hist == {$past(lk_hist[HIST_W-2:0]), $past(lk_taken)});

    // R8
    mispredict_restore_chk: assert property (@(posedge clk) disable iff (rst)
        (up_mispredict && !lk_valid) |=>
            lk_hist == {$past(up_hist[HIST_W-2:0]), $past(up_taken)});

    // R9
    history_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!lk_valid && !up_mispredict) |=> $stable(lk_hist));

    // R10
    no_flag_when_correct_chk: assert property (@(posedge clk) disable iff (rst)
        (!up_valid || up_pred == up_taken) |-> !up_mispredict);
endmodule

bind gsp_hybrid_predictor gsp_checker #(
    .PC_W (PC_W),
    .IDX_W(IDX_W),
    .LOW_W(LOW_W),
    .ALIGN(ALIGN)
) u_gsp_checker (
    .clk          (clk),
    .rst          (rst),
    .lk_valid     (lk_valid),
    .lk_pc        (lk_pc),
    .lk_taken     (lk_taken),
    .lk_idx       (lk_idx),
    .lk_hist      (lk_hist),
    .up_valid     (up_valid),
    .up_hist      (up_hist),
    .up_pred      (up_pred),
    .up_taken     (up_taken),
    .up_mispredict(up_mispredict)
);

// File: tb/test_gsp_hybrid_predictor.sv
module test_gsp_hybrid_predictor;
    localparam int CLK_PERIOD = 10;
    localparam int PC_W   = 16;
    localparam int IDX_W  = 6;
    localparam int LOW_W  = 3;
    localparam int ALIGN  = 2;
    localparam int HIST_W = IDX_W - LOW_W;
    localparam int DEPTH  = 1 << IDX_W;

    logic              clk = 1'b0;
    logic              rst;
    logic              lk_valid;
    logic [PC_W-1:0]   lk_pc;
    logic              lk_taken;
    logic [IDX_W-1:0]  lk_idx;
    logic [HIST_W-1:0] lk_hist;
    logic              up_valid;
    logic [IDX_W-1:0]  up_idx;
    logic [HIST_W-1:0] up_hist;
    logic              up_pred;
    logic              up_taken;
    logic              up_mispredict;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    logic [1:0]        m_cnt [DEPTH];
    logic [HIST_W-1:0] m_hist;

    always #(CLK_PERIOD/2) clk = ~clk;

    gsp_hybrid_predictor #(
        .PC_W (PC_W),
        .IDX_W(IDX_W),
        .LOW_W(LOW_W),
        .ALIGN(ALIGN)
    ) i_gsp_hybrid_predictor (
        .clk          (clk),
        .rst          (rst),
        .lk_valid     (lk_valid),
        .lk_pc        (lk_pc),
        .lk_taken     (lk_taken),
        .lk_idx       (lk_idx),
        .lk_hist      (lk_hist),
        .up_valid     (up_valid),
        .up_idx       (up_idx),
        .up_hist      (up_hist),
        .up_pred      (up_pred),
        .up_taken     (up_taken),
        .up_mispredict(up_mispredict)
    );

    function automatic logic [IDX_W-1:0] m_index(input logic [PC_W-1:0] pc,
                                                 input logic [HIST_W-1:0] h);
        return {pc[ALIGN+IDX_W-1:ALIGN+LOW_W] ^ h, pc[ALIGN+LOW_W-1:ALIGN]};
    endfunction

    function automatic logic [PC_W-1:0] pc_for(input logic [IDX_W-1:0] idx,
                                               input logic [HIST_W-1:0] h);
        logic [PC_W-1:0] p;
        p = '0;
        p[ALIGN+LOW_W-1:ALIGN] = idx[LOW_W-1:0];
        p[ALIGN+IDX_W-1:ALIGN+LOW_W] = idx[IDX_W-1:LOW_W] ^ h;
        return p;
    endfunction

    function automatic logic [1:0] m_train(input logic [1:0] c, input logic t);
        if (t)  return (c == 2'd3) ? 2'd3 : c + 2'd1;
        return (c == 2'd0) ? 2'd0 : c - 2'd1;
    endfunction

    task automatic chk(input string msg, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", msg, act, exp);
        end
    endtask

    // one clock: drive after the falling edge, check before the rising edge
    task automatic cycle(input string tag, input logic lv, input logic [PC_W-1:0] pc,
                         input logic uv, input logic [IDX_W-1:0] ui,
                         input logic [HIST_W-1:0] uh, input logic up, input logic ut);
        logic [IDX_W-1:0]  e_idx;
        logic              e_tk;
        logic [HIST_W-1:0] base;
        lk_valid = lv; lk_pc = pc;
        up_valid = uv; up_idx = ui; up_hist = uh; up_pred = up; up_taken = ut;
        #1;
        e_idx = m_index(pc, m_hist);
        e_tk  = m_cnt[e_idx][1];
        if (lv) begin
            chk({tag, " R2 low index"}, int'(lk_idx[LOW_W-1:0]), int'(e_idx[LOW_W-1:0]));
            chk({tag, " R3 high index"}, int'(lk_idx[IDX_W-1:LOW_W]), int'(e_idx[IDX_W-1:LOW_W]));
            chk({tag, " R4 direction"}, int'(lk_taken), int'(e_tk));
        end
        chk({tag, " R12 history"}, int'(lk_hist), int'(m_hist));
        chk({tag, " R10 flag"}, int'(up_mispredict), int'(uv && (up != ut)));
        @(posedge clk);
        if (uv) m_cnt[ui] = m_train(m_cnt[ui], ut);
        base = (uv && up != ut) ? {uh[HIST_W-2:0], ut} : m_hist;
        m_hist = lv ? {base[HIST_W-2:0], e_tk} : base;
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        rst = 1'b1; lk_valid = 0; lk_pc = '0; up_valid = 0; up_idx = '0;
        up_hist = '0; up_pred = 0; up_taken = 0;
        for (int i = 0; i < DEPTH; i++) m_cnt[i] = 2'b01;
        m_hist = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 history after reset", int'(lk_hist), 0);

        // R1: every slot predicts not-taken after reset
        for (int p = 0; p < DEPTH; p++) begin
            lk_valid = 1; lk_pc = PC_W'(p << ALIGN);
            #1;
            chk("R1 reset prediction", int'(lk_taken), 0);
            cycle("R1", 1, PC_W'(p << ALIGN), 0, '0, '0, 0, 0);
        end

        // R8 restore to each history value, then R3 sweep of every slot
        for (int h = 0; h < (1 << HIST_W); h++) begin
            cycle("R8", 0, '0, 1, IDX_W'(h), HIST_W'(h >> 1), ~h[0], h[0]);
            chk("R8 restored history", int'(lk_hist), h);
            for (int p = 0; p < DEPTH; p++) begin
                cycle("R3", 1, PC_W'(p << ALIGN), 0, '0, '0, 0, 0);
            end
        end

        // R6 / R5: train one entry up past 3, then down past 0
        for (int k = 0; k < 5; k++) begin
            cycle("R9", 0, '0, 1, IDX_W'(5), '0, 1, 1);
            cycle("R6", 1, pc_for(IDX_W'(5), m_hist), 0, '0, '0, 0, 0);
        end
        chk("R5 upper saturation", int'(m_cnt[5]), 3);
        cycle("R5", 0, '0, 1, IDX_W'(5), '0, 0, 0);
        cycle("R5", 1, pc_for(IDX_W'(5), m_hist), 0, '0, '0, 0, 0);
        for (int k = 0; k < 5; k++) begin
            cycle("R6", 0, '0, 1, IDX_W'(5), '0, 0, 0);
        end
        cycle("R5", 0, '0, 1, IDX_W'(5), '0, 1, 1);
        lk_valid = 1; lk_pc = pc_for(IDX_W'(5), m_hist);
        #1;
        chk("R5 lower saturation then one taken", int'(lk_taken), 0);
        cycle("R5", 1, pc_for(IDX_W'(5), m_hist), 0, '0, '0, 0, 0);

        // R11: same-entry lookup and update see the old counter
        cycle("R11", 0, '0, 1, IDX_W'(9), '0, 1, 1);
        lk_valid = 1; lk_pc = pc_for(IDX_W'(9), m_hist);
        #1;
        chk("R11 collision old value", int'(lk_taken), 1);
        cycle("R11", 1, pc_for(IDX_W'(9), m_hist), 1, IDX_W'(9), '0, 1, 0);
        cycle("R11", 1, pc_for(IDX_W'(9), m_hist), 0, '0, '0, 0, 0);

        // R10 flag combinations, R8 restore with same-cycle lookup
        cycle("R10", 0, '0, 1, IDX_W'(3), 3'b101, 0, 0);
        cycle("R10", 0, '0, 1, IDX_W'(3), 3'b101, 1, 1);
        cycle("R10", 0, '0, 0, IDX_W'(3), 3'b101, 1, 0);
        cycle("R8", 1, 16'h0044, 1, IDX_W'(3), 3'b110, 0, 1);

        // R7 mixed traffic
        lf = 16'hACE1;
        for (int n = 0; n < 3000; n++) begin
            logic [15:0] r;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            r  = lf;
            cycle("R7", r[0], {r[15:8], r[7:0]} ^ 16'h5A3C, r[1],
                  IDX_W'(r[13:8]), HIST_W'(r[6:4]), r[2], r[3]);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule